// File: doc/BRIEF.md
# Carrier and Sampling-Phase Sequencer

This block produces the two complementary antenna drive signals of a contactless reader from a fast reference clock. The clock is divided by a prescaler and then by a carrier divider, so one carrier period spans `PRE_DIV*CAR_DIV` clock cycles. The default is 64 cycles, which gives 125 kHz from 8 MHz. In the same period the block places a short sample-and-hold strobe. The strobe position is held as a 4-bit code in steps of 1/32 of a period (11.25°). Codes 0 to 15 cover -78.75° to +90° around the falling edge of `drv_a`.

After a reset or a wake pulse, the block arms a one-shot phase evaluation. While the drivers run, it watches the digitised antenna signal `ant_ph` for a falling edge inside a fixed window around the drive falling edge. It turns the position of that edge into a new strobe code, and the new code takes effect at the start of the next carrier period.

A preload timer drives `preload_en` to charge the comparator reference capacitor. It fires after each driver turn-on, after reset and after a wake pulse. Each trigger has its own start delay, and both share one load length.

Top module: `carrier_phase_seq`

## Requirements
- R1: While running, `drv_a` is high for cycle indices 0..31 of each 64-cycle period and low for 32..63. Index 0 is the cycle after the edge that samples `drv_en` high. `drv_b` is always the complement of `drv_a`.
- R2: From the cycle after an edge that samples `drv_en` low, `drv_a`=0, `drv_b`=1 and `sample_stb`=0. The reset state is the same.
- R3: While running, `sample_stb` is high for exactly 4 consecutive cycles once per period. Its first cycle is at index 18+2·code. Index 32 is where `drv_a` falls (0°), and code k stands for phase -78.75°+11.25°·k.
- R4: After reset the code is 8 (+11.25°), so the strobe starts at index 34.
- R5: While armed and running, the first cycle index c in 24..55 that samples `ant_ph`=0, with `ant_ph`=1 sampled in the previous cycle, does two things. It sets code = min(15, 4 + floor((c-24)/2)), and it disarms the evaluation.
- R6: A newly measured code does not alter the strobe of the period in which it was measured. It applies from the next period onward.
- R7: The evaluation is armed only by reset and by a cycle with `wake`=1. Edges seen while disarmed leave the code unchanged.
- R8: A turn-on (edge sampling `drv_en`=1 while stopped) raises `preload_en` at the 2048th following edge. It stays high for 1024 cycles.
- R9: The first edge after reset release, or an edge sampling `wake`=1, raises `preload_en` at the 4144th following edge. It stays high for 1024 cycles.
- R10: A new trigger restarts the preload timer from its start. A wake in the same cycle as a turn-on takes the wake delay.
- R11: `ant_ph` falling edges at indices outside 24..55 are ignored and keep the evaluation armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (8 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Antenna driver enable |
| wake | input | 1 | Wake event pulse; re-arms evaluation and restarts preload timing |
| ant_ph | input | 1 | Digitised antenna phase signal |
| drv_a | output | 1 | Antenna drive, phase reference |
| drv_b | output | 1 | Complementary antenna drive |
| sample_stb | output | 1 | Sample-and-hold strobe |
| preload_en | output | 1 | Reference-capacitor preload window |

## Verification
The assertions check, on every cycle, that the two drives stay complementary and that the outputs are quiet after the enable drops. They also check that a strobe never runs past its width, that a preload window never exceeds its length, and that a wake always cancels a running preload. Only the directed scenarios can show where the strobe sits inside the period and how a measured edge position maps to a clamped code. The same holds for the deferral of a new code to the next period, the one-shot arming, and the exact start delays of the preload for each trigger kind and for competing triggers.

// File: rtl/csq_pkg.sv
package csq_pkg;

    typedef enum logic [1:0] {
        PL_IDLE = 2'd0,
        PL_WAIT = 2'd1,
        PL_LOAD = 2'd2
    } pl_state_e;

endpackage

// File: rtl/csq_carrier.sv
module csq_carrier #(
    parameter int PERIOD = 64,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drv_en,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             drv_a,
    output logic             drv_b,
    output logic             turn_on
);

    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(PERIOD / 2);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             drv_a;
        logic             drv_b;
    } car_t;

    car_t car_d, car_q;

    always_comb begin
        car_d     = car_q;
        car_d.run = drv_en;
        if (drv_en && car_q.run) begin
            car_d.cnt = (car_q.cnt == LAST_C) ? '0 : car_q.cnt + 1'b1;
        end else begin
            car_d.cnt = '0;
        end
        // first half of the period drives high, falling edge marks 0 degrees
        car_d.drv_a = drv_en && (car_d.cnt < HALF_C);
        car_d.drv_b = !drv_en || (car_d.cnt >= HALF_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car_q <= '{run: 1'b0, cnt: '0, drv_a: 1'b0, drv_b: 1'b1};
        end else begin
            car_q <= car_d;
        end
    end

    assign cnt     = car_q.cnt;
    assign run     = car_q.run;
    assign drv_a   = car_q.drv_a;
    assign drv_b   = car_q.drv_b;
    assign turn_on = drv_en && !car_q.run;

endmodule

// File: rtl/csq_phase.sv
module csq_phase #(
    parameter int PERIOD     = 64,
    parameter int NPOS       = 16,
    parameter int STEP       = 2,
    parameter int STB_CYC    = 4,
    parameter int RESET_CODE = 8,
    parameter int LOW_STEPS  = 7,
    parameter int ANT_STEPS  = 4,
    parameter int CNT_W      = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wake,
    input  logic             ant_ph,
    output logic             sample_stb
);

    localparam int CODE_W  = $clog2(NPOS);
    localparam int HALF    = PERIOD / 2;
    localparam int BASE    = HALF - LOW_STEPS * STEP;
    localparam int WIN_LO  = HALF - ANT_STEPS * STEP;
    localparam int WIN_HI  = WIN_LO + NPOS * STEP - 1;
    localparam int EV_BASE = RESET_CODE - ANT_STEPS;

    localparam logic [CNT_W-1:0]  BASE_C   = CNT_W'(BASE);
    localparam logic [CNT_W-1:0]  WIN_LO_C = CNT_W'(WIN_LO);
    localparam logic [CNT_W-1:0]  WIN_HI_C = CNT_W'(WIN_HI);
    localparam logic [CNT_W-1:0]  STEP_C   = CNT_W'(STEP);
    localparam logic [CNT_W-1:0]  STB_C    = CNT_W'(STB_CYC);
    localparam logic [CNT_W-1:0]  LAST_C   = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0]  EVB_C    = CNT_W'(EV_BASE);
    localparam logic [CNT_W-1:0]  MAXC_W   = CNT_W'(NPOS - 1);
    localparam logic [CODE_W-1:0] MAXC     = CODE_W'(NPOS - 1);
    localparam logic [CODE_W-1:0] RST_C    = CODE_W'(RESET_CODE);

    typedef struct packed {
        logic              armed;
        logic              prev;
        logic [CODE_W-1:0] meas;
        logic [CODE_W-1:0] app;
    } ph_t;

    ph_t ph_d, ph_q;

    logic [CNT_W-1:0]  meas_off, meas_steps, meas_sum;
    logic [CODE_W-1:0] meas_code;
    logic              in_win;
    logic [CNT_W-1:0]  stb_start, stb_off;

    always_comb begin
        ph_d      = ph_q;
        ph_d.prev = ant_ph;

        // edge position relative to the -45 degree window start, in steps
        meas_off   = cnt - WIN_LO_C;
        meas_steps = meas_off / STEP_C;
        meas_sum   = meas_steps + EVB_C;
        meas_code  = (meas_sum > MAXC_W) ? MAXC : meas_sum[CODE_W-1:0];
        in_win     = (cnt >= WIN_LO_C) && (cnt <= WIN_HI_C);

        if (wake) begin
            ph_d.armed = 1'b1;
        end else if (ph_q.armed && run && in_win && ph_q.prev && !ant_ph) begin
            ph_d.meas  = meas_code;
            ph_d.armed = 1'b0;
        end

        // new code only takes effect on a period boundary
        if (!run || cnt == LAST_C) begin
            ph_d.app = ph_q.meas;
        end

        stb_start = BASE_C + STEP_C * CNT_W'(ph_q.app);
        stb_off   = cnt - stb_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '{armed: 1'b1, prev: 1'b0, meas: RST_C, app: RST_C};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign sample_stb = run && (stb_off < STB_C);

endmodule

// File: rtl/csq_preload.sv
module csq_preload
    import csq_pkg::*;
#(
    parameter int ON_DLY   = 2048,
    parameter int WAKE_DLY = 4144,
    parameter int PL_LEN   = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic turn_on,
    input  logic wake,
    output logic preload_en
);

    localparam int MAXD  = (ON_DLY > WAKE_DLY) ? ON_DLY : WAKE_DLY;
    localparam int MAXV  = (MAXD > PL_LEN) ? MAXD : PL_LEN;
    localparam int TMR_W = $clog2(MAXV + 1);

    localparam logic [TMR_W-1:0] ON_M1   = TMR_W'(ON_DLY - 1);
    localparam logic [TMR_W-1:0] WAKE_M1 = TMR_W'(WAKE_DLY - 1);
    localparam logic [TMR_W-1:0] WAKE_RS = TMR_W'(WAKE_DLY);
    localparam logic [TMR_W-1:0] LEN_M1  = TMR_W'(PL_LEN - 1);

    typedef struct packed {
        pl_state_e        st;
        logic [TMR_W-1:0] tmr;
    } pl_t;

    pl_t pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        if (wake) begin
            pl_d.st  = PL_WAIT;
            pl_d.tmr = WAKE_M1;
        end else if (turn_on) begin
            pl_d.st  = PL_WAIT;
            pl_d.tmr = ON_M1;
        end else begin
            case (pl_q.st)
                PL_WAIT: begin
                    if (pl_q.tmr == '0) begin
                        pl_d.st  = PL_LOAD;
                        pl_d.tmr = LEN_M1;
                    end else begin
                        pl_d.tmr = pl_q.tmr - 1'b1;
                    end
                end
                PL_LOAD: begin
                    if (pl_q.tmr == '0) begin
                        pl_d.st  = PL_IDLE;
                        pl_d.tmr = '0;
                    end else begin
                        pl_d.tmr = pl_q.tmr - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // reset value one above the wake delay: the first live edge acts as trigger
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q <= '{st: PL_WAIT, tmr: WAKE_RS};
        end else begin
            pl_q <= pl_d;
        end
    end

    assign preload_en = (pl_q.st == PL_LOAD);

endmodule

// File: rtl/carrier_phase_seq.sv
module carrier_phase_seq #(
    parameter int PRE_DIV    = 2,
    parameter int CAR_DIV    = 32,
    parameter int NPOS       = 16,
    parameter int STB_CYC    = 4,
    parameter int RESET_CODE = 8,
    parameter int LOW_STEPS  = 7,
    parameter int ANT_STEPS  = 4,
    parameter int ON_DLY     = 2048,
    parameter int WAKE_DLY   = 4144,
    parameter int PL_LEN     = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic wake,
    input  logic ant_ph,
    output logic drv_a,
    output logic drv_b,
    output logic sample_stb,
    output logic preload_en
);

    localparam int PERIOD = PRE_DIV * CAR_DIV;
    localparam int CNT_W  = $clog2(PERIOD);
    localparam int STEP   = PERIOD / (2 * NPOS);

    logic [CNT_W-1:0] cnt;
    logic             run;
    logic             turn_on;

    csq_carrier #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv_en  (drv_en),
        .cnt     (cnt),
        .run     (run),
        .drv_a   (drv_a),
        .drv_b   (drv_b),
        .turn_on (turn_on)
    );

    csq_phase #(
        .PERIOD     (PERIOD),
        .NPOS       (NPOS),
        .STEP       (STEP),
        .STB_CYC    (STB_CYC),
        .RESET_CODE (RESET_CODE),
        .LOW_STEPS  (LOW_STEPS),
        .ANT_STEPS  (ANT_STEPS),
        .CNT_W      (CNT_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cnt        (cnt),
        .wake       (wake),
        .ant_ph     (ant_ph),
        .sample_stb (sample_stb)
    );

    csq_preload #(
        .ON_DLY   (ON_DLY),
        .WAKE_DLY (WAKE_DLY),
        .PL_LEN   (PL_LEN)
    ) u_preload (
        .clk        (clk),
        .rst_n      (rst_n),
        .turn_on    (turn_on),
        .wake       (wake),
        .preload_en (preload_en)
    );

endmodule

// File: rtl/csq_checker.sv
module csq_checker #(
    parameter int STB_CYC = 4,
    parameter int PL_LEN  = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic drv_en,
    input logic wake,
    input logic drv_a,
    input logic drv_b,
    input logic sample_stb,
    input logic preload_en
);

    localparam int SW = $clog2(STB_CYC + 1) + 1;
    localparam int PW = $clog2(PL_LEN + 1) + 1;

    logic [SW-1:0] stb_len_q;
    logic [PW-1:0] pl_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_len_q <= '0;
            pl_len_q  <= '0;
        end else begin
            stb_len_q <= !sample_stb ? '0 : (stb_len_q == '1 ? stb_len_q : stb_len_q + 1'b1);
            pl_len_q  <= !preload_en ? '0 : (pl_len_q == '1 ? pl_len_q : pl_len_q + 1'b1);
        end
    end

    a_r1_drv_complement: assert property (@(posedge clk) disable iff (!rst_n)
        drv_a != drv_b);

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(drv_en) |-> (!drv_a && drv_b && !sample_stb));

    a_r3_stb_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (stb_len_q < SW'(STB_CYC)));

    a_r8_preload_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |-> (pl_len_q < PW'(PL_LEN)));

    a_r10_wake_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !preload_en);

endmodule

bind carrier_phase_seq csq_checker #(
    .STB_CYC (STB_CYC),
    .PL_LEN  (PL_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv_en     (drv_en),
    .wake       (wake),
    .drv_a      (drv_a),
    .drv_b      (drv_b),
    .sample_stb (sample_stb),
    .preload_en (preload_en)
);

// File: tb/carrier_phase_seq_test.sv
`timescale 1ns/1ps
module carrier_phase_seq_test;

    localparam int CLK_PERIOD = 125;
    localparam int ON_DLY     = 2048;
    localparam int WAKE_DLY   = 4144;
    localparam int PL_LEN     = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_en = 1'b0;
    logic wake = 1'b0;
    logic ant_ph = 1'b1;
    logic drv_a, drv_b, sample_stb, preload_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    carrier_phase_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .drv_en     (drv_en),
        .wake       (wake),
        .ant_ph     (ant_ph),
        .drv_a      (drv_a),
        .drv_b      (drv_b),
        .sample_stb (sample_stb),
        .preload_en (preload_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; drv_en = 1'b0; wake = 1'b0; ant_ph = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wake_pulse();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    // leaves the caller at the negedge inside index 0 of a period
    task automatic find_start();
        logic last;
        last = drv_a;
        forever begin
            @(negedge clk);
            if (drv_a && !last) break;
            last = drv_a;
        end
    endtask

    task automatic measure(output int st, output int w);
        find_start();
        st = -1; w = 0;
        for (int i = 0; i < 64; i++) begin
            if (i > 0) @(negedge clk);
            if (sample_stb) begin
                if (st < 0) st = i;
                w++;
            end
        end
    endtask

    task automatic sense_at(input int c);
        find_start();
        repeat (c) @(negedge clk);
        ant_ph = 1'b0;
        @(negedge clk);
        ant_ph = 1'b1;
    endtask

    task automatic expect_start(input string req, input int exp_st);
        int st, w;
        measure(st, w);
        chk(st == exp_st, req, st, exp_st);
        chk(w == 4, "R3 width", w, 4);
    endtask

    // trigger is the posedge after the negedge at which the caller set it
    task automatic preload_window(input string req, input int d);
        @(negedge clk);
        wake = 1'b0;
        repeat (d - 1) @(negedge clk);
        chk(preload_en == 1'b0, {req, " before delay"}, preload_en, 0);
        @(negedge clk);
        chk(preload_en == 1'b1, {req, " at delay"}, preload_en, 1);
        repeat (PL_LEN - 1) @(negedge clk);
        chk(preload_en == 1'b1, {req, " last load cycle"}, preload_en, 1);
        @(negedge clk);
        chk(preload_en == 1'b0, {req, " after load"}, preload_en, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(drv_a == 1'b0, "R2 reset drv_a", drv_a, 0);
        chk(drv_b == 1'b1, "R2 reset drv_b", drv_b, 1);
        chk(sample_stb == 1'b0, "R2 reset strobe", sample_stb, 0);
        chk(preload_en == 1'b0, "R9 reset preload idle", preload_en, 0);
    endtask

    task automatic t_preload_after_reset();
        do_reset();
        preload_window("R9 reset", WAKE_DLY);
    endtask

    task automatic t_drive_and_turn_on();
        int bad;
        do_reset();
        @(negedge clk);
        drv_en = 1'b1;
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (drv_a != ((i % 64) < 32) || drv_b != !((i % 64) < 32)) bad++;
        end
        chk(bad == 0, "R1 drive waveform mismatches", bad, 0);
        drv_en = 1'b0;
        @(negedge clk);
        chk(drv_a == 1'b0 && drv_b == 1'b1, "R2 drivers off", {drv_a, drv_b}, 1);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (sample_stb) bad++;
        end
        chk(bad == 0, "R2 strobe suppressed", bad, 0);
        // re-enable restarts the preload delay (R10)
        drv_en = 1'b1;
        preload_window("R8 R10 turn-on", ON_DLY);
    endtask

    task automatic t_wake_priority();
        drv_en = 1'b0;
        repeat (3) @(negedge clk);
        wake = 1'b1;
        drv_en = 1'b1;
        preload_window("R10 wake over turn-on", WAKE_DLY);
    endtask

    task automatic t_default_phase();
        do_reset();
        @(negedge clk);
        drv_en = 1'b1;
        expect_start("R4 reset code strobe", 34);
    endtask

    task automatic t_evaluation();
        sense_at(10);
        expect_start("R11 edge before window", 34);
        sense_at(40);
        expect_start("R5 code 12", 42);
        sense_at(28);
        expect_start("R7 disarmed edge ignored", 42);
        wake_pulse();
        sense_at(28);
        expect_start("R7 wake re-arms code 6", 30);
    endtask

    task automatic t_clamp_and_window();
        wake_pulse();
        sense_at(55);
        expect_start("R5 clamp to 15", 48);
        wake_pulse();
        sense_at(56);
        expect_start("R11 edge after window", 48);
        sense_at(31);
        expect_start("R11 still armed code 7", 32);
        wake_pulse();
        sense_at(23);
        expect_start("R11 edge at 23", 32);
    endtask

    task automatic t_deferral();
        int st, w;
        find_start();
        repeat (24) @(negedge clk);
        ant_ph = 1'b0;
        st = -1; w = 0;
        for (int i = 25; i < 64; i++) begin
            @(negedge clk);
            if (i == 25) ant_ph = 1'b1;
            if (sample_stb) begin
                if (st < 0) st = i;
                w++;
            end
        end
        chk(st == 32, "R6 old code kept in measuring period", st, 32);
        chk(w == 4, "R6 old strobe full width", w, 4);
        expect_start("R5 R6 code 4 next period", 26);
    endtask

    initial begin
        t_reset_state();
        t_preload_after_reset();
        t_drive_and_turn_on();
        t_wake_priority();
        t_default_phase();
        t_evaluation();
        t_clamp_and_window();
        t_deferral();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule